// File: doc/BRIEF.md
# Descriptor Ring Index Unit

This block keeps the pointer state of a single descriptor ring shared between a host and a transfer engine. The host programs the ring's base address and entry count and then posts work by advancing a producer index. The transfer engine fetches the descriptor the consumer index points at and, when it has finished, pulses a one-cycle strobe that moves the consumer index forward. From the two indices the block derives the ring's fill level, the free slot count and a work-pending level. It also compares the fill level against two programmable occupancy marks.

The ring length is a power of two, so every index wraps by ANDing with the entry count minus one. One slot always stays unused, which means a ring of N entries carries at most N − 1 outstanding descriptors and "empty" is simply the two indices being equal. The consumer index is visible as a read-only register, so the host can poll it. The block holds no descriptor storage and moves no data.

Top module: `ring_idx_unit`

## Requirements
- R1: After reset every register reads 0, the ring is disabled (`ring_en` low), and `fill_cnt`, `free_cnt`, `work_pending`, `wm_low` and `wm_high` are all 0.
- R2: Register offsets are 0x00 base address, 0x04 entry count, 0x08 producer index, 0x0C consumer index and 0x10 occupancy marks. A write updates only the byte lanes whose `reg_be` bit is set. Reads are combinational in the same cycle. Any other offset reads 0, and a write to such an offset changes nothing.
- R3: A write to the entry count register makes the ring enabled when the new value is nonzero and disabled when it is 0. The same write clears both indices, sets the low mark to 0 and sets the high mark to the new entry count.
- R4: A value written to the producer index is stored ANDed with (entry count − 1). While the ring is disabled, the stored value is therefore 0.
- R5: Host writes to the consumer index register have no effect.
- R6: Each `consume` strobe advances the consumer index by one, modulo the entry count, when the indices differ. A strobe is ignored when the ring is empty or disabled.
- R7: `fill_cnt` = (prod − cons) & mask and `free_cnt` = (cons − 1 − prod) & mask, with mask = entry count − 1. Their sum is always N − 1, so a ring holding N − 1 entries reports zero free slots.
- R8: `work_pending` is high exactly when the ring is enabled and the two indices differ.
- R9: `wm_low` is high while the ring is enabled and `fill_cnt` is below the low mark. `wm_high` is high while the ring is enabled and `fill_cnt` is above the high mark. Both are levels, and both are 0 while the ring is disabled.
- R10: The low mark sits in bits 15:0 and the high mark in bits 31:16 of the marks register. With byte enables, each mark can be rewritten without touching the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_be | input | 4 | Byte-lane write enables |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| consume | input | 1 | One-cycle strobe from the transfer engine |
| ring_en | output | 1 | Ring enabled (entry count nonzero) |
| cons_idx | output | IDX_W | Current consumer index |
| fill_cnt | output | IDX_W | Outstanding descriptors |
| free_cnt | output | IDX_W | Slots the host may still fill |
| work_pending | output | 1 | Indices differ |
| wm_low | output | 1 | Fill level below the low mark |
| wm_high | output | 1 | Fill level above the high mark |

## Verification
Every register write and every `consume` strobe lands on the next rising edge. All status outputs are combinational decodes of that registered state, so each result is due one edge after its stimulus, and the read data is due in the same cycle as the address. The bench drives stimulus on falling edges and holds it for one full cycle. It checks at the following falling edge, or 1 ns after it places a read address, so every sample falls after the single register stage has settled. The wrap past the last slot, the full ring with N − 1 entries and strobes on an empty ring each get their own directed check.

// File: rtl/ring_idx_pkg.sv
package ring_idx_pkg;

    localparam int REG_AW = 5;
    localparam int REG_DW = 32;
    localparam int MARK_W = 16;

    typedef enum logic [2:0] {
        RG_BASE = 3'd0,
        RG_SIZE = 3'd1,
        RG_PROD = 3'd2,
        RG_CONS = 3'd3,
        RG_MARK = 3'd4
    } reg_sel_e;

    function automatic logic [REG_DW-1:0] lane_merge(
        input logic [REG_DW-1:0]   old_v,
        input logic [REG_DW-1:0]   new_v,
        input logic [REG_DW/8-1:0] be
    );
        logic [REG_DW-1:0] res;
        res = old_v;
        for (int b = 0; b < REG_DW/8; b++) begin
            if (be[b]) res[b*8 +: 8] = new_v[b*8 +: 8];
        end
        return res;
    endfunction

endpackage

// File: rtl/ring_idx_decode.sv
module ring_idx_decode
    import ring_idx_pkg::*;
#(
    parameter int IDX_W = 12
) (
    input  logic [REG_AW-1:0] addr,
    input  logic [31:0]       base_q,
    input  logic [IDX_W:0]    size_q,
    input  logic [IDX_W-1:0]  prod_q,
    input  logic [IDX_W-1:0]  cons_q,
    input  logic [MARK_W-1:0] lo_q,
    input  logic [MARK_W-1:0] hi_q,
    output reg_sel_e          sel,
    output logic              sel_ok,
    output logic [REG_DW-1:0] rdata
);

    localparam logic [2:0] LAST_WORD = 3'd4;

    logic [2:0] word;

    always_comb begin
        word   = addr[REG_AW-1:2];
        sel    = reg_sel_e'(word);
        sel_ok = (addr[1:0] == 2'b00) && (word <= LAST_WORD);
    end

    always_comb begin
        rdata = '0;
        if (sel_ok) begin
            case (sel)
                RG_BASE: rdata = base_q;
                RG_SIZE: rdata = REG_DW'(size_q);
                RG_PROD: rdata = REG_DW'(prod_q);
                RG_CONS: rdata = REG_DW'(cons_q);
                RG_MARK: rdata = {hi_q, lo_q};
                default: rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/ring_idx_state.sv
module ring_idx_state
    import ring_idx_pkg::*;
#(
    parameter int IDX_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  reg_sel_e            sel,
    input  logic                sel_ok,
    input  logic [REG_DW/8-1:0] be,
    input  logic [REG_DW-1:0]   wdata,
    input  logic                consume,
    output logic [31:0]         base_q,
    output logic [IDX_W:0]      size_q,
    output logic [IDX_W-1:0]    prod_q,
    output logic [IDX_W-1:0]    cons_q,
    output logic [MARK_W-1:0]   lo_q,
    output logic [MARK_W-1:0]   hi_q,
    output logic [IDX_W-1:0]    mask,
    output logic                en
);

    typedef struct packed {
        logic [31:0]       base;
        logic [IDX_W:0]    size;
        logic [IDX_W-1:0]  prod;
        logic [IDX_W-1:0]  cons;
        logic [MARK_W-1:0] lo;
        logic [MARK_W-1:0] hi;
    } ring_st_t;

    ring_st_t st_d, st_q;

    logic [IDX_W:0]    size_m1;
    logic              size_hit;
    logic [REG_DW-1:0] merged;

    always_comb begin
        en       = |st_q.size;
        size_m1  = st_q.size - 1'b1;
        mask     = en ? size_m1[IDX_W-1:0] : '0;
        size_hit = wr_en && sel_ok && (sel == RG_SIZE);
        merged   = '0;
        st_d     = st_q;

        if (consume && en && (st_q.cons != st_q.prod)) begin
            st_d.cons = (st_q.cons + 1'b1) & mask;
        end

        if (wr_en && sel_ok) begin
            case (sel)
                RG_BASE: begin
                    st_d.base = lane_merge(st_q.base, wdata, be);
                end
                RG_SIZE: begin
                    merged    = lane_merge(REG_DW'(st_q.size), wdata, be);
                    st_d.size = merged[IDX_W:0];
                    st_d.prod = '0;
                    st_d.cons = '0;
                    st_d.lo   = '0;
                    st_d.hi   = MARK_W'(merged[IDX_W:0]);
                end
                RG_PROD: begin
                    merged    = lane_merge(REG_DW'(st_q.prod), wdata, be);
                    st_d.prod = merged[IDX_W-1:0] & mask;
                end
                RG_MARK: begin
                    merged  = lane_merge({st_q.hi, st_q.lo}, wdata, be);
                    st_d.lo = merged[MARK_W-1:0];
                    st_d.hi = merged[REG_DW-1:MARK_W];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign base_q = st_q.base;
    assign size_q = st_q.size;
    assign prod_q = st_q.prod;
    assign cons_q = st_q.cons;
    assign lo_q   = st_q.lo;
    assign hi_q   = st_q.hi;

    AST_CONS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (consume && en && (st_q.cons != st_q.prod) && !size_hit)
        |=> (st_q.cons == IDX_W'(($past(st_q.cons) + 1'b1) & $past(mask)))); // R6

    AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.cons == st_q.prod) && !size_hit) |=> $stable(st_q.cons)); // R6

    AST_CONS_HOST_RO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel_ok && (sel == RG_CONS) && !consume) |=> $stable(st_q.cons)); // R5

    AST_PROD_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.prod & ~mask) == '0)); // R4

    AST_SIZE_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        size_hit |=> ((st_q.prod == '0) && (st_q.cons == '0) && (st_q.lo == '0)
                      && (st_q.hi == MARK_W'(st_q.size)))); // R3

endmodule

// File: rtl/ring_idx_calc.sv
module ring_idx_calc
    import ring_idx_pkg::*;
#(
    parameter int IDX_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [IDX_W-1:0]  mask,
    input  logic [IDX_W-1:0]  prod_q,
    input  logic [IDX_W-1:0]  cons_q,
    input  logic [MARK_W-1:0] lo_q,
    input  logic [MARK_W-1:0] hi_q,
    output logic [IDX_W-1:0]  fill,
    output logic [IDX_W-1:0]  free,
    output logic              pending,
    output logic              wm_low,
    output logic              wm_high
);

    logic [MARK_W-1:0] fill_ext;

    always_comb begin
        fill     = (prod_q - cons_q) & mask;
        free     = (cons_q - 1'b1 - prod_q) & mask;
        pending  = en && (prod_q != cons_q);
        fill_ext = MARK_W'(fill);
        wm_low   = en && (fill_ext < lo_q);
        wm_high  = en && (fill_ext > hi_q);
    end

    AST_FILL_FREE_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (IDX_W'(fill + free) == mask)); // R7

    AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !pending |-> (fill == '0)); // R8

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (!wm_low && !wm_high && (free == '0))); // R9

endmodule

// File: rtl/ring_idx_unit.sv
module ring_idx_unit
    import ring_idx_pkg::*;
#(
    parameter int IDX_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [4:0]        reg_addr,
    input  logic [3:0]        reg_be,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              consume,
    output logic              ring_en,
    output logic [IDX_W-1:0]  cons_idx,
    output logic [IDX_W-1:0]  fill_cnt,
    output logic [IDX_W-1:0]  free_cnt,
    output logic              work_pending,
    output logic              wm_low,
    output logic              wm_high
);

    reg_sel_e          sel;
    logic              sel_ok;
    logic [31:0]       base_q;
    logic [IDX_W:0]    size_q;
    logic [IDX_W-1:0]  prod_q;
    logic [IDX_W-1:0]  cons_q;
    logic [MARK_W-1:0] lo_q;
    logic [MARK_W-1:0] hi_q;
    logic [IDX_W-1:0]  mask;
    logic              en;

    ring_idx_decode #(.IDX_W(IDX_W)) u_decode (
        .addr   (reg_addr),
        .base_q (base_q),
        .size_q (size_q),
        .prod_q (prod_q),
        .cons_q (cons_q),
        .lo_q   (lo_q),
        .hi_q   (hi_q),
        .sel    (sel),
        .sel_ok (sel_ok),
        .rdata  (reg_rdata)
    );

    ring_idx_state #(.IDX_W(IDX_W)) u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en),
        .sel     (sel),
        .sel_ok  (sel_ok),
        .be      (reg_be),
        .wdata   (reg_wdata),
        .consume (consume),
        .base_q  (base_q),
        .size_q  (size_q),
        .prod_q  (prod_q),
        .cons_q  (cons_q),
        .lo_q    (lo_q),
        .hi_q    (hi_q),
        .mask    (mask),
        .en      (en)
    );

    ring_idx_calc #(.IDX_W(IDX_W)) u_calc (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .mask    (mask),
        .prod_q  (prod_q),
        .cons_q  (cons_q),
        .lo_q    (lo_q),
        .hi_q    (hi_q),
        .fill    (fill_cnt),
        .free    (free_cnt),
        .pending (work_pending),
        .wm_low  (wm_low),
        .wm_high (wm_high)
    );

    assign ring_en  = en;
    assign cons_idx = cons_q;

endmodule

// File: tb/ring_idx_unit_tb_top.sv
module ring_idx_unit_tb_top;

    localparam int IDX_W = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr_en = 1'b0;
    logic [4:0]        reg_addr = '0;
    logic [3:0]        reg_be = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              consume = 1'b0;
    logic              ring_en;
    logic [IDX_W-1:0]  cons_idx;
    logic [IDX_W-1:0]  fill_cnt;
    logic [IDX_W-1:0]  free_cnt;
    logic              work_pending;
    logic              wm_low;
    logic              wm_high;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    ring_idx_unit #(.IDX_W(IDX_W)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_wr_en    (reg_wr_en),
        .reg_addr     (reg_addr),
        .reg_be       (reg_be),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .consume      (consume),
        .ring_en      (ring_en),
        .cons_idx     (cons_idx),
        .fill_cnt     (fill_cnt),
        .free_cnt     (free_cnt),
        .work_pending (work_pending),
        .wm_low       (wm_low),
        .wm_high      (wm_high)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    task automatic reg_wr(input logic [4:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_be = be; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0; reg_be = '0;
    endtask

    task automatic reg_rd(input logic [4:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic strobe(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); consume = 1'b1;
            @(negedge clk); consume = 1'b0;
        end
    endtask

    task automatic check_ring(input string tag, input int fill, input int free, input logic pend);
        check({tag, " fill"}, 32'(fill_cnt), 32'(fill));
        check({tag, " free"}, 32'(free_cnt), 32'(free));
        check({tag, " pending"}, 32'(work_pending), 32'(pend));
    endtask

    task automatic t_reset;
        logic [31:0] d;
        for (int a = 0; a < 5; a++) begin
            reg_rd(5'(a * 4), d);
            check("R1 reg after reset", d, 32'h0);
        end
        check("R1 ring_en", 32'(ring_en), 0);
        check_ring("R1", 0, 0, 1'b0);
        check("R1 wm_low", 32'(wm_low), 0);
        check("R1 wm_high", 32'(wm_high), 0);
    endtask

    task automatic t_regmap;
        logic [31:0] d;
        reg_wr(5'h00, 4'hF, 32'hDEADBEEF);
        reg_rd(5'h00, d); check("R2 base full write", d, 32'hDEADBEEF);
        reg_wr(5'h00, 4'h1, 32'h12345655);
        reg_rd(5'h00, d); check("R2 base byte lane", d, 32'hDEADBE55);
        reg_wr(5'h14, 4'hF, 32'hFFFFFFFF);
        reg_rd(5'h14, d); check("R2 unmapped read", d, 32'h0);
        reg_rd(5'h00, d); check("R2 unmapped write no effect", d, 32'hDEADBE55);
        reg_wr(5'h08, 4'hF, 32'h5);
        reg_rd(5'h08, d); check("R4 prod while disabled", d, 32'h0);
    endtask

    task automatic t_size;
        logic [31:0] d;
        reg_wr(5'h04, 4'hF, 32'd8);
        check("R3 ring_en", 32'(ring_en), 1);
        reg_rd(5'h04, d); check("R3 size read", d, 32'd8);
        reg_rd(5'h10, d); check("R3 marks init", d, 32'h0008_0000);
        check_ring("R7 empty", 0, 7, 1'b0);
    endtask

    task automatic t_prod;
        logic [31:0] d;
        reg_wr(5'h08, 4'hF, 32'd5);
        check_ring("R7 R8 prod5", 5, 2, 1'b1);
        reg_wr(5'h08, 4'hF, 32'd13);
        reg_rd(5'h08, d); check("R4 prod masked", d, 32'd5);
    endtask

    task automatic t_cons_ro;
        logic [31:0] d;
        reg_wr(5'h0C, 4'hF, 32'd7);
        reg_rd(5'h0C, d); check("R5 cons reg read-only", d, 32'd0);
        check("R5 cons_idx", 32'(cons_idx), 0);
    endtask

    task automatic t_consume;
        logic [31:0] d;
        strobe(2);
        check("R6 cons after 2", 32'(cons_idx), 2);
        check_ring("R7 after 2", 3, 4, 1'b1);
        strobe(3);
        check("R6 cons reaches prod", 32'(cons_idx), 5);
        check_ring("R8 empty", 0, 7, 1'b0);
        strobe(1);
        reg_rd(5'h0C, d); check("R6 empty strobe ignored", d, 32'd5);
        reg_wr(5'h08, 4'hF, 32'd3);
        check_ring("R7 wrapped prod", 6, 1, 1'b1);
        strobe(6);
        check("R6 cons wraps", 32'(cons_idx), 3);
        reg_wr(5'h08, 4'hF, 32'd2);
        check_ring("R7 full ring", 7, 0, 1'b1);
        strobe(7);
        check("R6 drain full", 32'(cons_idx), 2);
    endtask

    task automatic t_marks;
        logic [31:0] d;
        reg_wr(5'h04, 4'hF, 32'd8);
        check("R3 size rewrite clears cons", 32'(cons_idx), 0);
        check("R9 no flags at init", 32'({wm_low, wm_high}), 0);
        reg_wr(5'h10, 4'h3, 32'h00AA_0002);
        reg_rd(5'h10, d); check("R10 low only", d, 32'h0008_0002);
        check("R9 low flag fill0", 32'(wm_low), 1);
        reg_wr(5'h08, 4'hF, 32'd2);
        check("R9 low clear at mark", 32'(wm_low), 0);
        reg_wr(5'h10, 4'hC, 32'h0003_00FF);
        reg_rd(5'h10, d); check("R10 high only", d, 32'h0003_0002);
        reg_wr(5'h08, 4'hF, 32'd4);
        check("R9 high flag fill4", 32'(wm_high), 1);
        strobe(1);
        check("R9 high clear fill3", 32'(wm_high), 0);
    endtask

    task automatic t_disable;
        logic [31:0] d;
        reg_wr(5'h04, 4'hF, 32'd0);
        check("R3 disabled", 32'(ring_en), 0);
        check_ring("R9 disabled", 0, 0, 1'b0);
        check("R9 flags off", 32'({wm_low, wm_high}), 0);
        reg_rd(5'h10, d); check("R3 marks zero", d, 32'h0);
        strobe(1);
        check("R6 strobe while disabled", 32'(cons_idx), 0);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual still running, expected finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_regmap;
        t_size;
        t_prod;
        t_cons_ro;
        t_consume;
        t_marks;
        t_disable;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule